// File: doc/BRIEF.md
# Trigger Combiner with Cross-Trigger Exchange

This block sits between the per-probe comparators of an on-chip logic analyzer and its capture logic. Each cycle it takes one hit bit per probe and merges them into a single trigger condition. The merge is a runtime choice: either every participating probe must hit in the same cycle, or any one of them is enough. Probes that only carry data are left out of the merge by a runtime mask. While the analyzer is armed, the first cycle in which the merged condition holds produces a one-cycle trigger event for capture. Every later match is ignored until the analyzer is disarmed and armed again.

The block also trades triggers with neighbouring analyzers, so that several of them can be chained. An incoming cross-trigger is registered and acknowledged with a one-cycle pulse. An outgoing cross-trigger is raised either by the local event or by the registered incoming trigger, chosen at runtime. It is held until the far side acknowledges it, using a four-phase handshake. Each cross-trigger direction can be removed at build time. When a direction is removed, its outputs are tied low.

Runtime settings are loaded through a small write-only register port. Writes only take effect while the analyzer is disarmed.

Top module: `trig_merge_unit`

## Requirements
- R1: After reset, trig_event, xtrig_out and xtrig_in_ack are all 0. The reset configuration is OR merge, local output source, and every probe participating.
- R2: In AND merge (control bit 0 = 1), trig_event is 1 in the cycle after the edge at which the analyzer is armed and every participating probe hit is 1. A partial match produces no event.
- R3: In OR merge (control bit 0 = 0), trig_event is 1 in the cycle after the edge at which the analyzer is armed and at least one participating probe hit is 1.
- R4: A probe whose mask bit is 0 is data-only. It counts as satisfied in AND merge and as not satisfied in OR merge, whatever its hit bit.
- R5: No event is produced while arm is 0. After arming, only the first matching cycle produces an event. Taking arm to 0 and back to 1 allows one further event.
- R6: trig_event is never high for two cycles in a row.
- R7: Configuration writes are accepted only while arm is 0. cfg_sel = 0 writes control (bit 0 selects AND merge, bit 1 selects the external output source). cfg_sel = 1 writes the participation mask. A write made while armed has no effect.
- R8: With the local source selected (control bit 1 = 0), xtrig_out rises one cycle after trig_event. It stays high until xtrig_out_ack is sampled high, and it falls on the next cycle. No new output is raised until the acknowledge has been seen low again.
- R9: With the external source selected (control bit 1 = 1), xtrig_out rises two cycles after xtrig_in rises. Local events are not forwarded to xtrig_out in this mode.
- R10: xtrig_in_ack is a one-cycle pulse two cycles after xtrig_in rises. A further pulse requires xtrig_in to go low first.
- R11: When the input path is disabled at build time, xtrig_in_ack stays 0. When the output path is disabled at build time, xtrig_out stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Analyzer armed level |
| probe_hit | input | NPROBE | One comparator hit bit per probe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control register, 1 = participation mask |
| cfg_wdata | input | NPROBE | Configuration write data |
| trig_event | output | 1 | One-cycle trigger event to capture logic |
| xtrig_in | input | 1 | Cross-trigger from a neighbouring analyzer |
| xtrig_in_ack | output | 1 | One-cycle acknowledge of xtrig_in |
| xtrig_out | output | 1 | Cross-trigger to a neighbouring analyzer |
| xtrig_out_ack | input | 1 | Acknowledge returned for xtrig_out |

## Verification
The local trigger event and an incoming cross-trigger can arrive in the same cycle. The bench provokes this by raising the probe hits and xtrig_in on the same clock, with the external output source selected. It then checks three things: trig_event pulses one cycle later, xtrig_out and xtrig_in_ack rise together one cycle after that, and no second output assertion follows once the handshake completes. This shows that exactly one trigger was forwarded, taken from the selected source.

// File: rtl/trig_merge_pkg.sv
// Package: shared constants and types for the trigger combiner.
// Assumes the probe count is at least 2 so that the control bits fit in the write data.
package trig_merge_pkg;

    // Control register bit positions
    localparam int CTRL_AND_BIT = 0;
    localparam int CTRL_SRC_BIT = 1;

    // Configuration register select
    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_MASK = 1'b1
    } cfg_sel_e;

    // Outgoing handshake states
    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_HOLD    = 2'd1,
        HS_RELEASE = 2'd2
    } hs_state_e;

endpackage

// File: rtl/trig_cfg_regs.sv
// Module: runtime configuration registers (merge mode, output source, probe mask).
// Assumes writes arrive while disarmed; writes seen while armed are dropped.
module trig_cfg_regs
    import trig_merge_pkg::*;
#(
    parameter int NPROBE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [NPROBE-1:0] cfg_wdata,
    output logic              and_mode,
    output logic              src_ext,
    output logic [NPROBE-1:0] mask
);

    logic wr_ok;
    assign wr_ok = cfg_wr && !arm;

    // Control register: merge mode and output source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            and_mode <= 1'b0;
            src_ext  <= 1'b0;
        end else if (wr_ok && (cfg_sel == 1'(SEL_CTRL))) begin
            and_mode <= cfg_wdata[CTRL_AND_BIT];
            src_ext  <= cfg_wdata[CTRL_SRC_BIT];
        end
    end

    // Participation mask register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (wr_ok && (cfg_sel == 1'(SEL_MASK))) begin
            mask <= cfg_wdata;
        end
    end

endmodule

// File: rtl/trig_combine.sv
// Module: merges per-probe hits into one condition.
// Assumes hits are already registered by the comparators; this is pure logic.
module trig_combine #(
    parameter int NPROBE = 8
) (
    input  logic [NPROBE-1:0] hit,
    input  logic [NPROBE-1:0] mask,
    input  logic              and_mode,
    output logic              cond
);

    logic [NPROBE-1:0] and_terms;
    logic [NPROBE-1:0] or_terms;

    // Per-probe terms: data-only probes are neutral for each merge
    for (genvar i = 0; i < NPROBE; i++) begin : g_term
        assign and_terms[i] = hit[i] | ~mask[i];
        assign or_terms[i]  = hit[i] &  mask[i];
    end

    // Final reduction picked by the runtime mode
    always_comb begin
        cond = and_mode ? (&and_terms) : (|or_terms);
    end

endmodule

// File: rtl/trig_arm_gate.sv
// Module: passes only the first condition after arming as a one-cycle event.
// Assumes arm is a level; dropping it re-enables a later event.
module trig_arm_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cond,
    output logic event_o
);

    logic fired;

    // Track whether this arming has already produced its event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired   <= 1'b0;
            event_o <= 1'b0;
        end else if (!arm) begin
            fired   <= 1'b0;
            event_o <= 1'b0;
        end else if (cond && !fired) begin
            fired   <= 1'b1;
            event_o <= 1'b1;
        end else begin
            event_o <= 1'b0;
        end
    end

endmodule

// File: rtl/xtrig_in_sync.sv
// Module: registers the incoming cross-trigger and pulses its acknowledge.
// Assumes the input is synchronous to clk; ENABLE = 0 ties the outputs low.
module xtrig_in_sync #(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xin,
    output logic rise,
    output logic ack
);

    if (ENABLE) begin : g_on
        logic xin_q;
        logic xin_d;

        // Capture the input and remember the previous capture
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                xin_q <= 1'b0;
                xin_d <= 1'b0;
            end else begin
                xin_q <= xin;
                xin_d <= xin_q;
            end
        end

        assign rise = xin_q && !xin_d;

        // One-cycle acknowledge per registered rising edge
        always_ff @(posedge clk) begin
            if (!rst_n) ack <= 1'b0;
            else        ack <= rise;
        end
    end else begin : g_off
        logic unused_in;
        assign unused_in = xin ^ clk ^ rst_n;
        assign rise = 1'b0;
        assign ack  = 1'b0;
    end

endmodule

// File: rtl/xtrig_out_hs.sv
// Module: four-phase handshake driver for the outgoing cross-trigger.
// Assumes requests arriving mid-handshake are dropped; ENABLE = 0 ties output low.
module xtrig_out_hs
    import trig_merge_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ack,
    output logic xout
);

    if (ENABLE) begin : g_on
        hs_state_e state;

        // Handshake sequence: raise, hold to ack, wait for ack low
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state <= HS_IDLE;
            end else begin
                unique case (state)
                    HS_IDLE:    if (req)  state <= HS_HOLD;
                    HS_HOLD:    if (ack)  state <= HS_RELEASE;
                    HS_RELEASE: if (!ack) state <= HS_IDLE;
                    default:              state <= HS_IDLE;
                endcase
            end
        end

        assign xout = (state == HS_HOLD);
    end else begin : g_off
        logic unused_in;
        assign unused_in = req ^ ack ^ clk ^ rst_n;
        assign xout = 1'b0;
    end

endmodule

// File: rtl/trig_merge_unit.sv
// Module: top of the trigger combiner with cross-trigger exchange.
// Assumes probe hits and cross-trigger signals are synchronous to clk.
module trig_merge_unit #(
    parameter int NPROBE  = 8,
    parameter bit XIN_EN  = 1'b1,
    parameter bit XOUT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [NPROBE-1:0] probe_hit,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [NPROBE-1:0] cfg_wdata,
    output logic              trig_event,
    input  logic              xtrig_in,
    output logic              xtrig_in_ack,
    output logic              xtrig_out,
    input  logic              xtrig_out_ack
);

    logic              cfg_and;
    logic              cfg_src_ext;
    logic [NPROBE-1:0] cfg_mask;
    logic              cond;
    logic              xin_rise;
    logic              out_req;

    trig_cfg_regs #(.NPROBE(NPROBE)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .and_mode  (cfg_and),
        .src_ext   (cfg_src_ext),
        .mask      (cfg_mask)
    );

    trig_combine #(.NPROBE(NPROBE)) u_comb (
        .hit      (probe_hit),
        .mask     (cfg_mask),
        .and_mode (cfg_and),
        .cond     (cond)
    );

    trig_arm_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .cond    (cond),
        .event_o (trig_event)
    );

    xtrig_in_sync #(.ENABLE(XIN_EN)) u_xin (
        .clk   (clk),
        .rst_n (rst_n),
        .xin   (xtrig_in),
        .rise  (xin_rise),
        .ack   (xtrig_in_ack)
    );

    // Output request source select
    always_comb begin
        out_req = cfg_src_ext ? xin_rise : trig_event;
    end

    xtrig_out_hs #(.ENABLE(XOUT_EN)) u_xout (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (out_req),
        .ack   (xtrig_out_ack),
        .xout  (xtrig_out)
    );

endmodule

// File: rtl/trig_merge_chk.sv
// Module: assertion checker bound to trig_merge_unit.
module trig_merge_chk #(
    parameter int NPROBE  = 8,
    parameter bit XIN_EN  = 1'b1,
    parameter bit XOUT_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              trig_event,
    input logic              xtrig_in,
    input logic              xtrig_in_ack,
    input logic              xtrig_out,
    input logic              xtrig_out_ack,
    input logic              cfg_and,
    input logic              cfg_src_ext,
    input logic [NPROBE-1:0] cfg_mask
);

    p_event_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_event |=> !trig_event);

    p_event_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig_event |-> $past(arm));

    p_cfg_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arm) && arm |-> $stable(cfg_mask) && $stable(cfg_and) && $stable(cfg_src_ext));

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xtrig_out && !xtrig_out_ack |=> xtrig_out);

    p_out_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xtrig_out && xtrig_out_ack |=> !xtrig_out);

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xtrig_in_ack |=> !xtrig_in_ack);

    p_ack_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xtrig_in_ack |-> $past(xtrig_in, 2));

    // R11: disabled paths keep their outputs low
    always_comb begin
        if (rst_n && !XOUT_EN) p_out_off_r11: assert (!xtrig_out);
        if (rst_n && !XIN_EN)  p_in_off_r11:  assert (!xtrig_in_ack);
    end

endmodule

bind trig_merge_unit trig_merge_chk #(
    .NPROBE  (NPROBE),
    .XIN_EN  (XIN_EN),
    .XOUT_EN (XOUT_EN)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm           (arm),
    .trig_event    (trig_event),
    .xtrig_in      (xtrig_in),
    .xtrig_in_ack  (xtrig_in_ack),
    .xtrig_out     (xtrig_out),
    .xtrig_out_ack (xtrig_out_ack),
    .cfg_and       (cfg_and),
    .cfg_src_ext   (cfg_src_ext),
    .cfg_mask      (cfg_mask)
);

// File: tb/test_trig_merge_unit.sv
module test_trig_merge_unit;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [NP-1:0] probe_hit = '0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [NP-1:0] cfg_wdata = '0;
    logic          trig_event, xtrig_in_ack, xtrig_out;
    logic          xtrig_in = 1'b0;
    logic          xtrig_out_ack = 1'b0;
    logic          ev_off, ack_off, out_off;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_merge_unit #(.NPROBE(NP)) i_trig_merge_unit (
        .clk(clk), .rst_n(rst_n), .arm(arm), .probe_hit(probe_hit),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .trig_event(trig_event), .xtrig_in(xtrig_in), .xtrig_in_ack(xtrig_in_ack),
        .xtrig_out(xtrig_out), .xtrig_out_ack(xtrig_out_ack)
    );

    trig_merge_unit #(.NPROBE(NP), .XIN_EN(1'b0), .XOUT_EN(1'b0)) i_off (
        .clk(clk), .rst_n(rst_n), .arm(arm), .probe_hit(probe_hit),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .trig_event(ev_off), .xtrig_in(xtrig_in), .xtrig_in_ack(ack_off),
        .xtrig_out(out_off), .xtrig_out_ack(xtrig_out_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic sel, input logic [NP-1:0] d);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_wr = 1'b0;
    endtask

    // Complete an open output handshake
    task automatic drain_out();
        xtrig_out_ack = 1'b1; tick();
        xtrig_out_ack = 1'b0; tick();
    endtask

    task automatic t_reset();
        chk("R1 trig_event", trig_event, 0);
        chk("R1 xtrig_out", xtrig_out, 0);
        chk("R1 xtrig_in_ack", xtrig_in_ack, 0);
    endtask

    task automatic t_or_mode();
        arm = 1'b1; tick();
        probe_hit = 8'h10; tick();
        chk("R3 or event", trig_event, 1);
        chk("R8 out not yet", xtrig_out, 0);
        probe_hit = 8'h00; tick();
        chk("R6 single cycle", trig_event, 0);
        chk("R8 out rises", xtrig_out, 1);
        tick(3);
        chk("R8 out held", xtrig_out, 1);
        xtrig_out_ack = 1'b1; tick();
        chk("R8 out falls", xtrig_out, 0);
        xtrig_out_ack = 1'b0; tick();
        probe_hit = 8'h01; tick();
        chk("R5 only first", trig_event, 0);
        tick();
        chk("R5 only first b", trig_event, 0);
        arm = 1'b0; probe_hit = 8'h00; tick();
    endtask

    task automatic t_and_mode();
        cfg_write(1'b0, 8'h01);
        arm = 1'b1; probe_hit = 8'h7F; tick();
        chk("R2 partial", trig_event, 0);
        tick();
        chk("R2 partial b", trig_event, 0);
        probe_hit = 8'hFF; tick();
        chk("R2 all hit", trig_event, 1);
        tick(); drain_out();
        arm = 1'b0; probe_hit = 8'h00; tick();
    endtask

    task automatic t_mask();
        cfg_write(1'b1, 8'h0F);
        arm = 1'b1; probe_hit = 8'h0F; tick();
        chk("R4 and masked true", trig_event, 1);
        tick(); drain_out();
        arm = 1'b0; probe_hit = 8'h00; tick();
        cfg_write(1'b0, 8'h00);
        arm = 1'b1; probe_hit = 8'hF0; tick();
        chk("R4 or masked false", trig_event, 0);
        tick(2);
        chk("R4 or masked false b", trig_event, 0);
        arm = 1'b0; probe_hit = 8'h00; tick();
        cfg_write(1'b1, 8'hFF);
    endtask

    task automatic t_disarmed_rearm();
        probe_hit = 8'hFF; tick();
        chk("R5 disarmed", trig_event, 0);
        tick();
        chk("R5 disarmed b", trig_event, 0);
        arm = 1'b1; tick();
        chk("R5 arm fires", trig_event, 1);
        tick(); drain_out();
        arm = 1'b0; tick();
        arm = 1'b1; tick();
        chk("R5 rearm fires", trig_event, 1);
        tick(); drain_out();
        arm = 1'b0; probe_hit = 8'h00; tick();
    endtask

    task automatic t_cfg_locked();
        arm = 1'b1; tick();
        cfg_write(1'b1, 8'h00);
        cfg_write(1'b0, 8'h01);
        probe_hit = 8'h01; tick();
        chk("R7 write ignored", trig_event, 1);
        tick(); drain_out();
        arm = 1'b0; probe_hit = 8'h00; tick();
    endtask

    task automatic t_xin();
        cfg_write(1'b0, 8'h02);
        xtrig_in = 1'b1; tick();
        chk("R10 ack not yet", xtrig_in_ack, 0);
        tick();
        chk("R10 ack pulse", xtrig_in_ack, 1);
        chk("R9 out from ext", xtrig_out, 1);
        tick();
        chk("R10 ack one cycle", xtrig_in_ack, 0);
        tick(2);
        chk("R10 no repeat", xtrig_in_ack, 0);
        drain_out();
        chk("R9 out released", xtrig_out, 0);
        xtrig_in = 1'b0; tick();
        arm = 1'b1; probe_hit = 8'h01; tick();
        chk("R9 local event", trig_event, 1);
        tick();
        chk("R9 local not forwarded", xtrig_out, 0);
        arm = 1'b0; probe_hit = 8'h00; tick();
    endtask

    task automatic t_same_cycle();
        arm = 1'b1; tick();
        probe_hit = 8'h01; xtrig_in = 1'b1; tick();
        chk("R3 same-cycle event", trig_event, 1);
        chk("R9 same-cycle out wait", xtrig_out, 0);
        tick();
        chk("R9 same-cycle out", xtrig_out, 1);
        chk("R10 same-cycle ack", xtrig_in_ack, 1);
        drain_out();
        tick(2);
        chk("R9 single forward", xtrig_out, 0);
        arm = 1'b0; probe_hit = 8'h00; xtrig_in = 1'b0; tick();
        cfg_write(1'b0, 8'h00);
    endtask

    // R11 monitor on the instance with both cross-trigger paths removed
    always @(negedge clk) begin
        if (rst_n && !done && (ack_off || out_off)) begin
            n_chk++; n_fail++;
            $display("FAIL R11: actual ack=%0d out=%0d expected 0 0", ack_off, out_off);
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_or_mode();
        t_and_mode();
        t_mask();
        t_disarmed_rearm();
        t_cfg_locked();
        t_xin();
        t_same_cycle();
        chk("R11 out tied", out_off, 0);
        chk("R11 ack tied", ack_off, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule